// File: doc/BRIEF.md
# Overhead Bit Transmit Register Bank with Boundary-Aligned Update

This block holds the transmit values of the overhead bits carried in every frame of a superframe. A superframe has eight frames, and each frame carries six overhead bits. A processor writes one six-bit word per frame slot. Each write lands in a pending copy. The value moves to the live copy only at a frame boundary strobe that opens a new superframe or, for slots in the half-superframe group, a new half-superframe. This way a frame never sends a mix of old and new settings.

A framer drives a strobe and a frame index at the start of each frame. On that clock edge the block registers the six overhead bits for the indexed frame, including any value committed on the same edge, and holds them for the whole frame. When enabled, a one-cycle sync pulse marks the start of each superframe. A write that arrives in the same clock as its own boundary strobe waits for the next boundary of its group.

Top module: `ohb_tx_regs`

## Requirements
- R1: After a synchronous reset, `m_bits` is 0, `sf_sync` is 0, and every live and pending slot value is 0.
- R2: A write to slot `wr_addr` changes only the pending copy. Strobes for that frame keep giving the old live value until its group's boundary has passed.
- R3: Slots outside the half group commit their pending value only on a strobe with `frame_idx` = 0. A strobe with `frame_idx` = 4 leaves them unchanged.
- R4: Slots whose bit in `HALF_MASK` is set (default: slots 4 to 7) commit on strobes with `frame_idx` = 0 and with `frame_idx` = 4.
- R5: A write in the same clock as a boundary strobe of its slot's group is not committed by that strobe. It is committed at the following boundary of that group.
- R6: On the clock edge of a strobe, `m_bits` takes the live value of slot `frame_idx` as it stands after that edge's commit. It keeps that value until the next strobe. Bit 0 is the first overhead bit of the frame and bit 5 the sixth; bit 3 is the activation-control position.
- R7: `sf_sync` is high for exactly the one cycle after the edge of a strobe with `frame_idx` = 0, and only when `sync_en` was high at that edge.
- R8: Several writes to one slot before its boundary leave only the last written value to be committed.
- R9: A reset asserted mid-run also discards pending writes, so no later boundary brings them out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Processor write strobe |
| wr_addr | input | 3 | Frame slot being written |
| wr_data | input | 6 | Overhead word for that slot |
| frame_strobe | input | 1 | One-cycle pulse at the start of each frame |
| frame_idx | input | 3 | Index of the frame beginning with the strobe (0 to 7) |
| sync_en | input | 1 | Enables the superframe sync pulse |
| m_bits | output | 6 | Overhead bits of the current frame |
| sf_sync | output | 1 | Superframe start pulse |

## Verification
The commit rule is tested with writes placed away from any boundary, writes on a half-superframe strobe, writes on a superframe strobe, and repeated writes to one slot. Each pattern is read back through later frame strobes, which separates a too-early commit, a wrong group assignment and a lost deferral. Cycles with no strobe after a superframe strobe show whether the output holds and whether the sync pulse lasts one cycle. A run with sync disabled and a mid-run reset separate the enable gating and the clearing of pending state from normal commits.

// File: rtl/ohb_pkg.sv
package ohb_pkg;

    localparam int OHB_FRAMES = 8;
    localparam int OHB_BITS   = 6;

    // Which boundaries may promote a slot's pending value
    typedef enum logic {
        COMMIT_SF   = 1'b0,
        COMMIT_HALF = 1'b1
    } commit_grp_t;

    // Boundary events decoded from the frame timing input
    typedef struct packed {
        logic sf;
        logic hsf;
    } ohb_edge_t;

    function automatic ohb_edge_t decode_edge(
        input logic        strobe,
        input int unsigned idx,
        input int unsigned half_idx
    );
        ohb_edge_t e;
        e.sf  = strobe && (idx == 0);
        e.hsf = strobe && (idx == half_idx);
        return e;
    endfunction

endpackage

// File: rtl/ohb_boundary.sv
module ohb_boundary
    import ohb_pkg::*;
#(
    parameter int NUM_FRAMES = OHB_FRAMES,
    localparam int FRAME_W   = $clog2(NUM_FRAMES),
    localparam int HALF_IDX  = NUM_FRAMES / 2
) (
    input  logic               frame_strobe,
    input  logic [FRAME_W-1:0] frame_idx,
    output ohb_edge_t          edges
);

    always_comb begin
        edges = decode_edge(frame_strobe, int'(frame_idx), HALF_IDX);
    end

endmodule

// File: rtl/ohb_slot.sv
module ohb_slot
    import ohb_pkg::*;
#(
    parameter int          W   = OHB_BITS,
    parameter commit_grp_t GRP = COMMIT_SF
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_data,
    input  ohb_edge_t    edges,
    output logic [W-1:0] active_q,
    output logic [W-1:0] active_nx
);

    logic [W-1:0] shadow_q;
    logic         pending_q;
    logic         commit;

    always_comb begin
        commit    = edges.sf || ((GRP == COMMIT_HALF) && edges.hsf);
        active_nx = (commit && pending_q) ? shadow_q : active_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q  <= '0;
            active_q  <= '0;
            pending_q <= 1'b0;
        end else begin
            if (commit && pending_q) begin
                active_q  <= shadow_q;
                pending_q <= 1'b0;
            end
            if (wr_hit) begin
                shadow_q  <= wr_data;
                pending_q <= 1'b1;
            end
        end
    end

    // R2 / R3: the live value never moves outside a boundary of this group
    a_r2_live_holds: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active_q));

    // R5: a write on a boundary edge stays pending after that edge
    a_r5_write_on_edge_deferred: assert property (@(posedge clk) disable iff (rst)
        (wr_hit && commit) |=> pending_q);

    // R8: a commit without a new write leaves nothing pending
    a_r8_commit_drains: assert property (@(posedge clk) disable iff (rst)
        (commit && !wr_hit) |=> !pending_q);

endmodule

// File: rtl/ohb_frame_sel.sv
module ohb_frame_sel
    import ohb_pkg::*;
#(
    parameter int NUM_FRAMES = OHB_FRAMES,
    parameter int W          = OHB_BITS,
    localparam int FRAME_W   = $clog2(NUM_FRAMES)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_FRAMES-1:0][W-1:0]   slot_nx,
    input  logic                           frame_strobe,
    input  logic [FRAME_W-1:0]             frame_idx,
    input  logic                           sf_edge,
    input  logic                           sync_en,
    output logic [W-1:0]                   m_bits,
    output logic                           sf_sync
);

    always_ff @(posedge clk) begin
        if (rst) begin
            m_bits  <= '0;
            sf_sync <= 1'b0;
        end else begin
            if (frame_strobe) begin
                m_bits <= slot_nx[frame_idx];
            end
            sf_sync <= sf_edge && sync_en;
        end
    end

    // R6: the frame word is held between strobes
    a_r6_word_held: assert property (@(posedge clk) disable iff (rst)
        !frame_strobe |=> $stable(m_bits));

    // R7: no pulse unless enabled at the previous edge
    a_r7_sync_gated: assert property (@(posedge clk) disable iff (rst)
        sf_sync |-> $past(sync_en && frame_strobe));

endmodule

// File: rtl/ohb_tx_regs.sv
module ohb_tx_regs
    import ohb_pkg::*;
#(
    parameter int NUM_FRAMES               = OHB_FRAMES,
    parameter int M_BITS                   = OHB_BITS,
    parameter logic [NUM_FRAMES-1:0] HALF_MASK = 8'hF0,
    localparam int FRAME_W                 = $clog2(NUM_FRAMES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_addr,
    input  logic [M_BITS-1:0]  wr_data,
    input  logic               frame_strobe,
    input  logic [FRAME_W-1:0] frame_idx,
    input  logic               sync_en,
    output logic [M_BITS-1:0]  m_bits,
    output logic               sf_sync
);

    ohb_edge_t                          edges;
    logic [NUM_FRAMES-1:0][M_BITS-1:0]  slot_q;
    logic [NUM_FRAMES-1:0][M_BITS-1:0]  slot_nx;

    ohb_boundary #(.NUM_FRAMES(NUM_FRAMES)) u_boundary (
        .frame_strobe (frame_strobe),
        .frame_idx    (frame_idx),
        .edges        (edges)
    );

    for (genvar s = 0; s < NUM_FRAMES; s++) begin : g_slot
        localparam commit_grp_t GRP = HALF_MASK[s] ? COMMIT_HALF : COMMIT_SF;
        logic hit;
        assign hit = wr_en && (wr_addr == FRAME_W'(s));

        ohb_slot #(.W(M_BITS), .GRP(GRP)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (hit),
            .wr_data   (wr_data),
            .edges     (edges),
            .active_q  (slot_q[s]),
            .active_nx (slot_nx[s])
        );
    end

    ohb_frame_sel #(.NUM_FRAMES(NUM_FRAMES), .W(M_BITS)) u_sel (
        .clk          (clk),
        .rst          (rst),
        .slot_nx      (slot_nx),
        .frame_strobe (frame_strobe),
        .frame_idx    (frame_idx),
        .sf_edge      (edges.sf),
        .sync_en      (sync_en),
        .m_bits       (m_bits),
        .sf_sync      (sf_sync)
    );

    // R1: outputs and live slots are cleared by reset
    a_r1_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (m_bits == '0 && !sf_sync && slot_q == '0));

    // R3: a half-superframe edge never also counts as a superframe edge
    a_r3_edges_distinct: assert property (@(posedge clk) disable iff (rst)
        !(edges.sf && edges.hsf));

endmodule

// File: tb/test_ohb_tx_regs.sv
module test_ohb_tx_regs;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [5:0] wr_data = '0;
    logic       frame_strobe = 1'b0;
    logic [2:0] frame_idx = '0;
    logic       sync_en = 1'b1;
    logic [5:0] m_bits;
    logic       sf_sync;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    ohb_tx_regs i_ohb_tx_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_strobe(frame_strobe), .frame_idx(frame_idx), .sync_en(sync_en),
        .m_bits(m_bits), .sf_sync(sf_sync)
    );

    typedef struct packed {
        logic       we;
        logic [2:0] wa;
        logic [5:0] wd;
        logic       st;
        logic [2:0] ix;
        logic [5:0] em;
        logic       es;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 3'd1, 6'h15, 1'b0, 3'd0, 6'h00, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd1, 6'h00, 1'b0},
        '{1'b1, 3'd5, 6'h2A, 1'b0, 3'd0, 6'h00, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd4, 6'h00, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd5, 6'h2A, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd0, 6'h00, 1'b1},
        '{1'b0, 3'd0, 6'h00, 1'b0, 3'd0, 6'h00, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd1, 6'h15, 1'b0},
        '{1'b1, 3'd0, 6'h3F, 1'b1, 3'd0, 6'h00, 1'b1},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd4, 6'h00, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd0, 6'h3F, 1'b1},
        '{1'b1, 3'd6, 6'h11, 1'b1, 3'd4, 6'h00, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd6, 6'h00, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd0, 6'h3F, 1'b1},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd6, 6'h11, 1'b0},
        '{1'b1, 3'd6, 6'h22, 1'b0, 3'd0, 6'h11, 1'b0},
        '{1'b1, 3'd6, 6'h33, 1'b0, 3'd0, 6'h11, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd4, 6'h00, 1'b0},
        '{1'b0, 3'd0, 6'h00, 1'b1, 3'd6, 6'h33, 1'b0}
    };

    localparam string TAG [NV] = '{
        "R2", "R2", "R2", "R4", "R4", "R3 R7", "R6 R7", "R3 R6", "R5 R7", "R5 R3",
        "R5", "R5", "R5", "R4", "R4", "R8", "R8", "R8", "R8"
    };

    task automatic check(input string req, input logic [5:0] exp_m, input logic exp_s);
        checks++;
        if (m_bits !== exp_m || sf_sync !== exp_s) begin
            fails++;
            $display("FAIL %s: m_bits=%h sf_sync=%b expected m_bits=%h sf_sync=%b",
                     req, m_bits, sf_sync, exp_m, exp_s);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge
    task automatic apply(input logic we, input logic [2:0] wa, input logic [5:0] wd,
                         input logic st, input logic [2:0] ix);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; frame_strobe = st; frame_idx = ix;
        @(negedge clk);
        wr_en = 1'b0; frame_strobe = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 6'h00, 1'b0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].we, VEC[i].wa, VEC[i].wd, VEC[i].st, VEC[i].ix);
            check(TAG[i], VEC[i].em, VEC[i].es);
        end

        // R7: disabled sync gives no pulse on a superframe strobe
        sync_en = 1'b0;
        apply(1'b0, 3'd0, 6'h00, 1'b1, 3'd0);
        check("R7", 6'h3F, 1'b0);
        sync_en = 1'b1;

        // R9: pending writes are discarded by a mid-run reset
        apply(1'b1, 3'd2, 6'h0C, 1'b0, 3'd0);
        apply(1'b1, 3'd7, 6'h1E, 1'b0, 3'd0);
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        check("R1", 6'h00, 1'b0);
        apply(1'b0, 3'd0, 6'h00, 1'b1, 3'd6);
        check("R9", 6'h00, 1'b0);
        apply(1'b0, 3'd0, 6'h00, 1'b1, 3'd0);
        check("R9", 6'h00, 1'b1);
        apply(1'b0, 3'd0, 6'h00, 1'b1, 3'd2);
        check("R9", 6'h00, 1'b0);
        apply(1'b0, 3'd0, 6'h00, 1'b1, 3'd4);
        apply(1'b0, 3'd0, 6'h00, 1'b1, 3'd7);
        check("R9", 6'h00, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule